// File: doc/BRIEF.md
# Deferred Condition Code Evaluator

This unit rebuilds the condition flags of a processor status word after the fact. The execution datapath does not compute flags as it runs. It records the class of the last flag-setting operation, its operand size, both operands, the result and, for multiplies, the upper product word. When the flags are needed, these recorded values go to this block, which computes negative, zero, overflow and carry (or, for the multiply-step class, the R flag). It then merges them into the incoming status word.

Carry is not taken from an adder carry-out. It is inferred from the sign bits of the two operands and the result at the chosen width (8, 16 or 32 bits). Subtract and compare invert the source before that inference and invert the carry after it.

The merge writes only the bits selected by a writable-flag mask, together with the extend (X) bit. While X is set, a computed zero can only keep the old Z bit; it can never set it.

The result is registered. One cycle after a request is accepted, the new status word appears together with a valid strobe.

Top module: `cc_eval`

## Requirements
Flag bit positions in the status word are C=0, V=1, Z=2, N=3, X=4 and R=8. The op codes are ADD=0, SUB=1, CMP=2, MCP=3, MULS=4, MULU=5, MOVE=6 and LIVE=7. The size codes are 0 for byte (sign bit 7, low 8 bits), 1 for half (sign bit 15, low 16 bits), and 2 or 3 for word (sign bit 31, all bits).

- R1: For ADD, a result with its sized sign bit at 1 sets N. It also sets V when both sized operand signs are 0, and otherwise sets C when both are 1.
- R2: For ADD, a result with its sized sign bit at 0 sets Z when the sized result is zero. It sets V when both operand signs are 1, and sets C when at least one operand sign is 1.
- R3: SUB and CMP apply the R1/R2 rules to the bitwise inverse of the source, then invert the computed C.
- R4: MCP applies the R1/R2 rules but writes the computed carry into R; its computed C is 0.
- R5: MOVE computes only N (sized sign of the result) and Z (sized result zero with sign clear); its computed V, C and R are 0.
- R6: MULS treats {hi,res} as a signed 64-bit value. It sets Z when the value is zero and N when it is negative. It sets V when hi is not all copies of res bit 31.
- R7: MULU treats {hi,res} as unsigned. It sets Z when the value is zero, N when bit 63 is 1, and V when hi is non-zero.
- R8: The write mask is flag_mask OR the X bit. Masked status bits take the computed flag value, and all other bits keep their value from ccs_in.
- R9: For every op except LIVE, X ends at 0. When x_flag is 1 and the computed Z is 1, the Z bit keeps its ccs_in value.
- R10: For LIVE, ccs_out equals ccs_in unchanged.
- R11: out_valid is in_valid delayed by one cycle. ccs_out updates only in the cycle after an accepted request and otherwise holds.
- R12: While reset is asserted, ccs_out and out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; the inputs are sampled when it is high |
| op | input | 3 | Recorded operation class |
| size | input | 2 | Operand size code |
| src | input | 32 | Recorded source operand |
| dst | input | 32 | Recorded destination operand |
| res | input | 32 | Recorded result (low product word for multiplies) |
| hi | input | 32 | Upper product word |
| flag_mask | input | 32 | Writable-flag mask |
| x_flag | input | 1 | Extended-arithmetic flag in effect |
| ccs_in | input | 32 | Current status word |
| out_valid | output | 1 | New status word valid |
| ccs_out | output | 32 | New status word |

## Verification
Directed add cases pair operand signs of (0,0), (1,1) and mixed with negative, positive and zero results. This separates the overflow path from the carry path on both branches of the result-sign test. The same patterns are repeated at byte and half size, with non-zero upper bits, to show that the width selection picks the correct sign and zero bits.

Subtract patterns with equal operands and with a borrow show the source inversion and the final carry flip. An MCP pattern shows that the carry lands in R and not in C.

Multiply cases set hi to zero, all ones, and mismatched against the sign of res. This distinguishes a true sign extension from an overflow and separates the signed and unsigned N and V rules. Mask, X and LIVE patterns, idle cycles, and a long random stream are then compared cycle by cycle against a behavioural model.

// File: rtl/cc_pkg.sv
package cc_pkg;

  typedef enum logic [2:0] {
    CC_ADD  = 3'd0,
    CC_SUB  = 3'd1,
    CC_CMP  = 3'd2,
    CC_MCP  = 3'd3,
    CC_MULS = 3'd4,
    CC_MULU = 3'd5,
    CC_MOVE = 3'd6,
    CC_LIVE = 3'd7
  } cc_op_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } cc_size_e;

  localparam int unsigned BIT_C = 0;
  localparam int unsigned BIT_V = 1;
  localparam int unsigned BIT_Z = 2;
  localparam int unsigned BIT_N = 3;
  localparam int unsigned BIT_X = 4;
  localparam int unsigned BIT_R = 8;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
    logic r;
  } cc_flags_t;

endpackage

// File: rtl/cc_arith_flags.sv
module cc_arith_flags
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  cc_op_e            op,
  input  cc_size_e          size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] res,
  output cc_flags_t         flags
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic              invert;
  logic [DATA_W-1:0] src_eff;
  logic [IDX_W-1:0]  sb;
  logic [DATA_W-1:0] zmask;
  logic              s_sign, d_sign, r_sign, r_zero, carry;

  always_comb begin
    invert  = (op == CC_SUB) || (op == CC_CMP);
    src_eff = invert ? ~src : src;
    unique case (size)
      SZ_BYTE: begin sb = IDX_W'(7);  zmask = DATA_W'(8'hFF);    end
      SZ_HALF: begin sb = IDX_W'(15); zmask = DATA_W'(16'hFFFF); end
      default: begin sb = IDX_W'(DATA_W-1); zmask = '1;          end
    endcase
    s_sign = src_eff[sb];
    d_sign = dst[sb];
    r_sign = res[sb];
    r_zero = ((res & zmask) == '0);

    flags = '0;
    carry = 1'b0;
    if (r_sign) begin
      flags.n = 1'b1;
      if (!s_sign && !d_sign) flags.v = 1'b1;
      else if (s_sign && d_sign) carry = 1'b1;
    end else begin
      flags.z = r_zero;
      flags.v = s_sign && d_sign;
      carry   = s_sign || d_sign;
    end
    if (invert) carry = ~carry;
    if (op == CC_MCP) flags.r = carry;
    else              flags.c = carry;
  end
endmodule

// File: rtl/cc_move_flags.sv
module cc_move_flags
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  cc_size_e          size,
  input  logic [DATA_W-1:0] res,
  output cc_flags_t         flags
);
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic [IDX_W-1:0]  sb;
  logic [DATA_W-1:0] zmask;

  always_comb begin
    unique case (size)
      SZ_BYTE: begin sb = IDX_W'(7);  zmask = DATA_W'(8'hFF);    end
      SZ_HALF: begin sb = IDX_W'(15); zmask = DATA_W'(16'hFFFF); end
      default: begin sb = IDX_W'(DATA_W-1); zmask = '1;          end
    endcase
    flags   = '0;
    flags.n = res[sb];
    flags.z = !res[sb] && ((res & zmask) == '0);
  end
endmodule

// File: rtl/cc_mul_flags.sv
module cc_mul_flags
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              is_signed,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] res,
  output cc_flags_t         flags
);
  localparam int unsigned PROD_W = 2 * DATA_W;

  logic [PROD_W-1:0] prod;

  always_comb begin
    prod    = {hi, res};
    flags   = '0;
    flags.z = (prod == '0);
    flags.n = prod[PROD_W-1];
    if (is_signed) flags.v = (hi != {DATA_W{res[DATA_W-1]}});
    else           flags.v = (hi != '0);
  end
endmodule

// File: rtl/cc_merge.sv
module cc_merge
  import cc_pkg::*;
#(
  parameter int unsigned ST_W = 32
) (
  input  cc_flags_t       flags,
  input  logic            x_flag,
  input  logic [ST_W-1:0] flag_mask,
  input  logic [ST_W-1:0] ccs_in,
  output logic [ST_W-1:0] ccs_new
);
  logic [ST_W-1:0] wmask;
  logic [ST_W-1:0] fvec;

  always_comb begin
    fvec        = '0;
    fvec[BIT_N] = flags.n;
    fvec[BIT_Z] = flags.z;
    fvec[BIT_V] = flags.v;
    fvec[BIT_C] = flags.c;
    fvec[BIT_R] = flags.r;
    wmask        = flag_mask;
    wmask[BIT_X] = 1'b1;
    if (x_flag && flags.z) wmask[BIT_Z] = 1'b0;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_bit
    assign ccs_new[i] = wmask[i] ? fvec[i] : ccs_in[i];
  end
endmodule

// File: rtl/cc_eval.sv
module cc_eval
  import cc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ST_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] dst,
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] hi,
  input  logic [ST_W-1:0]   flag_mask,
  input  logic              x_flag,
  input  logic [ST_W-1:0]   ccs_in,
  output logic              out_valid,
  output logic [ST_W-1:0]   ccs_out
);
  cc_op_e          op_e;
  cc_size_e        size_e;
  cc_flags_t       arith_f, move_f, mul_f, sel_f;
  logic [ST_W-1:0] merged;
  logic [ST_W-1:0] ccs_next;
  logic            valid_next;
  logic            ccs_en;

  assign op_e   = cc_op_e'(op);
  assign size_e = cc_size_e'(size);

  cc_arith_flags #(.DATA_W(DATA_W)) u_arith (
    .op(op_e), .size(size_e), .src(src), .dst(dst), .res(res), .flags(arith_f)
  );

  cc_move_flags #(.DATA_W(DATA_W)) u_move (
    .size(size_e), .res(res), .flags(move_f)
  );

  cc_mul_flags #(.DATA_W(DATA_W)) u_mul (
    .is_signed(op_e == CC_MULS), .hi(hi), .res(res), .flags(mul_f)
  );

  cc_merge #(.ST_W(ST_W)) u_merge (
    .flags(sel_f), .x_flag(x_flag), .flag_mask(flag_mask),
    .ccs_in(ccs_in), .ccs_new(merged)
  );

  always_comb begin
    unique case (op_e)
      CC_ADD, CC_SUB, CC_CMP, CC_MCP: sel_f = arith_f;
      CC_MULS, CC_MULU:               sel_f = mul_f;
      CC_MOVE:                        sel_f = move_f;
      default:                        sel_f = '0;
    endcase
    ccs_next   = (op_e == CC_LIVE) ? ccs_in : merged;
    ccs_en     = in_valid;
    valid_next = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccs_out   <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_next;
      if (ccs_en) ccs_out <= ccs_next;
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(ccs_out));

  // R10
  live_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'd7) |=> (ccs_out == $past(ccs_in)));

  // R9
  x_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 3'd7) |=> !ccs_out[BIT_X]);

  // R9
  z_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 3'd7 && x_flag && !ccs_in[BIT_Z]) |=> !ccs_out[BIT_Z]);

  // R8
  unmasked_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op != 3'd7) |=>
      (((ccs_out ^ $past(ccs_in)) & ~($past(flag_mask) | (ST_W'(1) << BIT_X))) == '0));
endmodule

// File: tb/cc_eval_test.sv
`timescale 1ns/1ps
module cc_eval_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  op;
  logic [1:0]  size;
  logic [31:0] src, dst, res, hi, flag_mask, ccs_in;
  logic        x_flag;
  logic        out_valid;
  logic [31:0] ccs_out;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_ccs;
  logic        exp_valid;
  string       cur_tag;

  localparam logic [31:0] FULL = 32'h0000_010F;

  cc_eval uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .size(size),
    .src(src), .dst(dst), .res(res), .hi(hi), .flag_mask(flag_mask),
    .x_flag(x_flag), .ccs_in(ccs_in), .out_valid(out_valid), .ccs_out(ccs_out)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] model(input int o, input int sz,
      input logic [31:0] s_in, input logic [31:0] d_in, input logic [31:0] r_in,
      input logic [31:0] h_in, input logic [31:0] m_in, input bit x,
      input logic [31:0] c_in);
    int w;
    logic [31:0] se, keep, fl, m;
    bit s, d, rn, rz, cy;
    longint sp;
    longint unsigned up;
    if (o == 7) return c_in;
    w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
    keep = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
    se = (o == 1 || o == 2) ? ~s_in : s_in;
    s = se[w-1]; d = d_in[w-1]; rn = r_in[w-1]; rz = ((r_in & keep) == 0);
    fl = 0; cy = 0;
    if (o <= 3) begin
      if (rn) begin
        fl[3] = 1;
        if (!s && !d) fl[1] = 1;
        else if (s && d) cy = 1;
      end else begin
        fl[2] = rz; fl[1] = s && d; cy = s || d;
      end
      if (o == 1 || o == 2) cy = !cy;
      if (o == 3) fl[8] = cy; else fl[0] = cy;
    end else if (o == 4) begin
      sp = longint'({h_in, r_in});
      fl[2] = (sp == 0); fl[3] = (sp < 0);
      fl[1] = (longint'($signed(h_in)) != (r_in[31] ? -64'sd1 : 64'sd0));
    end else if (o == 5) begin
      up = {h_in, r_in};
      fl[2] = (up == 0); fl[3] = up[63]; fl[1] = (h_in != 0);
    end else begin
      fl[3] = rn; fl[2] = !rn && rz;
    end
    m = m_in | 32'h10;
    if (x && fl[2]) m[2] = 0;
    return (c_in & ~m) | (fl & m);
  endfunction

  task automatic compare();
    checks++;
    if (out_valid !== exp_valid || ccs_out !== exp_ccs) begin
      fails++;
      $display("FAIL %s: ccs_out=%h out_valid=%b expected ccs_out=%h out_valid=%b",
               cur_tag, ccs_out, out_valid, exp_ccs, exp_valid);
    end
  endtask

  task automatic step(input string tag, input bit v, input int o, input int sz,
      input logic [31:0] s_in, input logic [31:0] d_in, input logic [31:0] r_in,
      input logic [31:0] h_in, input logic [31:0] m_in, input bit x,
      input logic [31:0] c_in);
    @(negedge clk);
    compare();
    in_valid = v; op = 3'(o); size = 2'(sz); src = s_in; dst = d_in; res = r_in;
    hi = h_in; flag_mask = m_in; x_flag = x; ccs_in = c_in;
    if (v) exp_ccs = model(o, sz, s_in, d_in, r_in, h_in, m_in, x, c_in);
    exp_valid = v;
    cur_tag = tag;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; op = 0; size = 0; src = 0; dst = 0; res = 0;
    hi = 0; flag_mask = 0; x_flag = 0; ccs_in = 0;
    exp_ccs = 0; exp_valid = 0; cur_tag = "R12 reset";
    repeat (3) @(negedge clk);
    compare();
    rst_n = 1'b1;
    // R1 add, negative result
    step("R1 add V", 1, 0, 2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, FULL, 0, 32'h0);
    step("R1 add C", 1, 0, 2, 32'h8000_0000, 32'h8000_0000, 32'h8000_0001, 0, FULL, 0, 32'h0);
    step("R1 add mixed", 1, 0, 2, 32'h8000_0000, 32'h1, 32'h8000_0001, 0, FULL, 0, 32'hF);
    // R2 add, non-negative result
    step("R2 add zero", 1, 0, 2, 0, 0, 0, 0, FULL, 0, 32'h0);
    step("R2 add ZVC", 1, 0, 2, 32'h8000_0000, 32'h8000_0000, 0, 0, FULL, 0, 32'h0);
    step("R2 add ZC", 1, 0, 2, 32'hFFFF_FFFF, 32'h1, 0, 0, FULL, 0, 32'h0);
    step("R2 add byte", 1, 0, 0, 32'h80, 32'h80, 32'h100, 0, FULL, 0, 32'h0);
    step("R1 add half", 1, 0, 1, 32'h7FFF, 32'h1, 32'hFFFF_8000, 0, FULL, 0, 32'h0);
    // R3 subtract / compare
    step("R3 sub equal", 1, 1, 2, 32'h1, 32'h1, 32'h0, 0, FULL, 0, 32'h1);
    step("R3 sub borrow", 1, 1, 2, 32'h2, 32'h1, 32'hFFFF_FFFF, 0, FULL, 0, 32'h0);
    step("R3 cmp byte", 1, 2, 0, 32'h05, 32'h03, 32'hFE, 0, FULL, 0, 32'h0);
    // R4 multiply-step
    step("R4 mcp R", 1, 3, 2, 32'h8000_0000, 32'h8000_0000, 32'h1, 0, FULL, 0, 32'h1);
    // R5 move
    step("R5 move byte N", 1, 6, 0, 32'h0, 32'h0, 32'h80, 0, FULL, 0, 32'h3);
    step("R5 move half Z", 1, 6, 1, 32'h0, 32'h0, 32'h1_0000, 0, FULL, 0, 32'h103);
    step("R5 move word", 1, 6, 2, 32'h0, 32'h0, 32'h0, 0, FULL, 0, 32'h0);
    // R6 signed multiply
    step("R6 muls neg", 1, 4, 2, 0, 0, 32'h8000_0000, 32'hFFFF_FFFF, FULL, 0, 32'h0);
    step("R6 muls ovf", 1, 4, 2, 0, 0, 32'h8000_0000, 32'h0, FULL, 0, 32'h0);
    step("R6 muls zero", 1, 4, 2, 0, 0, 32'h0, 32'h0, FULL, 0, 32'h2);
    // R7 unsigned multiply
    step("R7 mulu hi", 1, 5, 2, 0, 0, 32'h0, 32'h1, FULL, 0, 32'h0);
    step("R7 mulu top", 1, 5, 2, 0, 0, 32'h5, 32'h8000_0000, FULL, 0, 32'h0);
    // R8 mask merge
    step("R8 mask N only", 1, 0, 2, 32'h7FFF_FFFF, 32'h1, 32'h8000_0000, 0, 32'h8, 0, 32'hFFFF_FFF7);
    step("R8 mask none", 1, 6, 2, 0, 0, 32'h0, 0, 32'h0, 0, 32'hA5A5_A5BF);
    // R9 extended arithmetic
    step("R9 x hold Z0", 1, 0, 2, 0, 0, 0, 0, FULL, 1, 32'h0000_0010);
    step("R9 x hold Z1", 1, 0, 2, 0, 0, 0, 0, FULL, 1, 32'h0000_0014);
    step("R9 x clear Z", 1, 0, 2, 0, 0, 32'h5, 0, FULL, 1, 32'h0000_0014);
    // R10 live
    step("R10 live", 1, 7, 2, 32'hFFFF_FFFF, 0, 0, 0, FULL, 1, 32'hDEAD_BEEF);
    // R11 idle cycles hold output
    step("R11 idle", 0, 0, 2, 32'h8000_0000, 32'h8000_0000, 0, 0, FULL, 0, 32'h0);
    step("R11 idle", 0, 6, 2, 0, 0, 0, 0, FULL, 0, 32'h0);
    step("R11 resume", 1, 0, 2, 1, 1, 2, 0, FULL, 0, 32'h0);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rs, rd, rr, rh, rm, rc;
      int ro;
      rs = $urandom; rd = $urandom; rr = $urandom; rh = $urandom; rc = $urandom;
      ro = $urandom_range(0, 7);
      if ((i % 4) == 0) rr = 0;
      if ((i % 5) == 0) rh = {32{rr[31]}};
      rm = ((i % 3) == 0) ? $urandom : FULL;
      step("R1-style random R8", ($urandom_range(0, 7) != 0), ro, $urandom_range(0, 3),
           rs, rd, rr, rh, rm, $urandom_range(0, 1) == 1, rc);
    end
    step("R11 drain", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    compare();
    summary();
  end
endmodule